// File: doc/BRIEF.md
# Load/Store Wait-State Interlock

This block controls a four-stage in-order pipeline: fetch, decode with effective-address generation, memory, and writeback. Each instruction carries a kind, a tag and two address operands. The decode stage adds the operands to form the effective address. That address travels with the instruction into the memory stage. While a load or store is in the memory stage, it drives a level bus request together with the address and the write flag.

When the bus responds without wait states, memory accesses run back to back. The next access computes its address in decode during the same cycle that the previous access sits in memory. An arithmetic instruction that consumes the result of the load just ahead of it moves on with no bubble.

A wait state on the bus freezes the memory stage. It also freezes everything behind the memory stage, and it withholds acceptance of new instructions. During each wait cycle an empty slot flows into writeback. The bus-ready input only matters while the memory stage holds a load or store.

Top module: `lsu_interlock`

## Requirements
- R1: While rst_ni is low, and after it is released until an instruction is accepted, every stage valid output is low, bus_req_o is low and in_ready_o is high.
- R2: With bus_ready_i high, an instruction accepted at a clock edge appears in fetch after that edge, then in decode, memory and writeback after the next three edges.
- R3: Two consecutive loads or stores flow with no bubble. The second one is in decode while the first is in memory.
- R4: An arithmetic instruction (kind 2'b00) directly behind a load (kind 2'b01) advances every cycle when the bus is ready.
- R5: bus_req_o is high exactly while the memory stage holds a load or a store (kind 2'b10). bus_addr_o equals the base plus the offset of that access, and bus_we_o is high only for a store.
- R6: While bus_req_o is high and bus_ready_i is low, the fetch, decode and memory stages keep their contents and in_ready_o is low.
- R7: Each wait cycle puts an empty slot into writeback. The access enters writeback at the edge where bus_ready_i is high.
- R8: bus_addr_o and bus_we_o stay unchanged across wait cycles, and bus_req_o stays high.
- R9: A held decode stage keeps its tag and its computed address (de_ea_o) unchanged until it advances.
- R10: bus_ready_i has no effect while the memory stage holds an arithmetic instruction or nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | New instruction present |
| in_kind_i | input | 2 | 00 arithmetic, 01 load, 10 store |
| in_tag_i | input | TAG_W | Instruction tag |
| in_base_i | input | ADDR_W | Address base operand |
| in_off_i | input | ADDR_W | Address offset operand |
| in_ready_o | output | 1 | Instruction accepted at next edge |
| bus_ready_i | input | 1 | Bus completes the pending access |
| bus_req_o | output | 1 | Access pending in memory stage |
| bus_we_o | output | 1 | Pending access is a store |
| bus_addr_o | output | ADDR_W | Effective address of pending access |
| if_valid_o | output | 1 | Fetch stage occupied |
| if_tag_o | output | TAG_W | Fetch stage tag |
| de_valid_o | output | 1 | Decode stage occupied |
| de_tag_o | output | TAG_W | Decode stage tag |
| de_ea_o | output | ADDR_W | Address computed in decode |
| mem_valid_o | output | 1 | Memory stage occupied |
| mem_tag_o | output | TAG_W | Memory stage tag |
| wb_valid_o | output | 1 | Writeback stage occupied |
| wb_tag_o | output | TAG_W | Writeback stage tag |

## Verification
Every stage register drives a tag and valid output. A corrupted hold or advance decision therefore shows up at the ports on the edge where it happens. The symptom is a tag that is duplicated, skipped or moved early, compared against a cycle-by-cycle reference schedule. A wrong wait decision also shows up at once, either as writeback occupied during a wait cycle or as a change in the bus address or decode address while the access is held. A wrong address path appears the first time the corrupted access reaches the memory stage, two edges after it is accepted.

// File: rtl/lsi_pkg.sv
package lsi_pkg;
  typedef enum logic [1:0] {
    K_ALU   = 2'b00,
    K_LOAD  = 2'b01,
    K_STORE = 2'b10
  } kind_e;

  function automatic logic is_access(input kind_e k);
    return (k == K_LOAD) || (k == K_STORE);
  endfunction
endpackage

// File: rtl/lsi_stage_reg.sv
module lsi_stage_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         d_valid_i,
  input  logic [W-1:0] d_data_i,
  output logic         q_valid_o,
  output logic [W-1:0] q_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_valid_o <= 1'b0;
      q_data_o  <= '0;
    end else if (en_i) begin
      q_valid_o <= d_valid_i;
      q_data_o  <= d_data_i;
    end
  end
endmodule

// File: rtl/lsi_agen.sv
module lsi_agen #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] off_i,
  output logic [ADDR_W-1:0] ea_o
);
  always_comb ea_o = base_i + off_i;
endmodule

// File: rtl/lsi_ctrl.sv
module lsi_ctrl
  import lsi_pkg::*;
(
  input  logic  mem_valid_i,
  input  kind_e mem_kind_i,
  input  logic  bus_ready_i,
  output logic  mem_access_o,
  output logic  mem_wait_o,
  output logic  front_en_o,
  output logic  wb_fill_o
);
  always_comb begin
    mem_access_o = mem_valid_i && is_access(mem_kind_i);
    // ready only counts while a real access sits in memory
    mem_wait_o   = mem_access_o && !bus_ready_i;
    front_en_o   = !mem_wait_o;
    wb_fill_o    = mem_valid_i && !mem_wait_o;
  end
endmodule

// File: rtl/lsu_interlock.sv
module lsu_interlock
  import lsi_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [1:0]        in_kind_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  input  logic [ADDR_W-1:0] in_base_i,
  input  logic [ADDR_W-1:0] in_off_i,
  output logic              in_ready_o,
  input  logic              bus_ready_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              if_valid_o,
  output logic [TAG_W-1:0]  if_tag_o,
  output logic              de_valid_o,
  output logic [TAG_W-1:0]  de_tag_o,
  output logic [ADDR_W-1:0] de_ea_o,
  output logic              mem_valid_o,
  output logic [TAG_W-1:0]  mem_tag_o,
  output logic              wb_valid_o,
  output logic [TAG_W-1:0]  wb_tag_o
);
  localparam int unsigned KW    = 2;
  localparam int unsigned FE_W  = KW + TAG_W + 2 * ADDR_W;
  localparam int unsigned MEM_W = KW + TAG_W + ADDR_W;

  logic front_en, mem_access, mem_wait, wb_fill;

  // fetch
  logic             if_v;
  logic [FE_W-1:0]  if_q;
  lsi_stage_reg #(.W(FE_W)) u_if (
    .clk_i, .rst_ni, .en_i(front_en),
    .d_valid_i(in_valid_i),
    .d_data_i({in_kind_i, in_tag_i, in_base_i, in_off_i}),
    .q_valid_o(if_v), .q_data_o(if_q)
  );

  // decode / address generation
  logic             de_v;
  logic [FE_W-1:0]  de_q;
  lsi_stage_reg #(.W(FE_W)) u_de (
    .clk_i, .rst_ni, .en_i(front_en),
    .d_valid_i(if_v), .d_data_i(if_q),
    .q_valid_o(de_v), .q_data_o(de_q)
  );

  kind_e             de_kind;
  logic [TAG_W-1:0]  de_tag;
  logic [ADDR_W-1:0] de_base, de_off, de_ea;
  assign de_kind = kind_e'(de_q[FE_W-1 -: KW]);
  assign de_tag  = de_q[2*ADDR_W +: TAG_W];
  assign de_base = de_q[ADDR_W +: ADDR_W];
  assign de_off  = de_q[0 +: ADDR_W];

  lsi_agen #(.ADDR_W(ADDR_W)) u_agen (
    .base_i(de_base), .off_i(de_off), .ea_o(de_ea)
  );

  // memory
  logic             mem_v;
  logic [MEM_W-1:0] mem_q;
  lsi_stage_reg #(.W(MEM_W)) u_mem (
    .clk_i, .rst_ni, .en_i(front_en),
    .d_valid_i(de_v), .d_data_i({de_kind, de_tag, de_ea}),
    .q_valid_o(mem_v), .q_data_o(mem_q)
  );

  kind_e             mem_kind;
  logic [TAG_W-1:0]  mem_tag;
  logic [ADDR_W-1:0] mem_ea;
  assign mem_kind = kind_e'(mem_q[MEM_W-1 -: KW]);
  assign mem_tag  = mem_q[ADDR_W +: TAG_W];
  assign mem_ea   = mem_q[0 +: ADDR_W];

  lsi_ctrl u_ctrl (
    .mem_valid_i(mem_v), .mem_kind_i(mem_kind), .bus_ready_i,
    .mem_access_o(mem_access), .mem_wait_o(mem_wait),
    .front_en_o(front_en), .wb_fill_o(wb_fill)
  );

  // writeback always loads; a wait cycle inserts a bubble
  logic             wb_v;
  logic [TAG_W-1:0] wb_q;
  lsi_stage_reg #(.W(TAG_W)) u_wb (
    .clk_i, .rst_ni, .en_i(1'b1),
    .d_valid_i(wb_fill), .d_data_i(mem_tag),
    .q_valid_o(wb_v), .q_data_o(wb_q)
  );

  assign in_ready_o  = front_en;
  assign bus_req_o   = mem_access;
  assign bus_we_o    = mem_access && (mem_kind == K_STORE);
  assign bus_addr_o  = mem_ea;
  assign if_valid_o  = if_v;
  assign if_tag_o    = if_q[2*ADDR_W +: TAG_W];
  assign de_valid_o  = de_v;
  assign de_tag_o    = de_tag;
  assign de_ea_o     = de_ea;
  assign mem_valid_o = mem_v;
  assign mem_tag_o   = mem_tag;
  assign wb_valid_o  = wb_v;
  assign wb_tag_o    = wb_q;

  // R8
  wait_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ready_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  // R9
  de_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ready_i) |=> ($stable(de_valid_o) && $stable(de_tag_o) && $stable(de_ea_o)));

  // R7
  wb_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ready_i) |=> !wb_valid_o);

  // R7
  wb_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ready_i) |=> (wb_valid_o && wb_tag_o == $past(mem_tag_o)));

  // R3
  overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_valid_o && in_ready_o) |=> (mem_valid_o && mem_tag_o == $past(de_tag_o)));
endmodule

// File: tb/sim_lsu_interlock.sv
module sim_lsu_interlock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_kind = 2'b00;
  logic [3:0]  in_tag = '0;
  logic [31:0] in_base = '0, in_off = '0;
  logic        bus_ready = 1'b1;
  logic        in_ready, bus_req, bus_we;
  logic [31:0] bus_addr, de_ea;
  logic        if_v, de_v, mem_v, wb_v;
  logic [3:0]  if_t, de_t, mem_t, wb_t;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lsu_interlock u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_kind_i(in_kind), .in_tag_i(in_tag),
    .in_base_i(in_base), .in_off_i(in_off), .in_ready_o(in_ready),
    .bus_ready_i(bus_ready), .bus_req_o(bus_req), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr),
    .if_valid_o(if_v), .if_tag_o(if_t),
    .de_valid_o(de_v), .de_tag_o(de_t), .de_ea_o(de_ea),
    .mem_valid_o(mem_v), .mem_tag_o(mem_t),
    .wb_valid_o(wb_v), .wb_tag_o(wb_t)
  );

  typedef struct packed {
    logic       iv;
    logic [1:0] kd;
    logic [3:0] tg;
    logic [7:0] ba;
    logic [7:0] of;
    logic       rd;
    logic [3:0] eif, ede, emem, ewb;
    logic       ereq, ewe;
    logic [7:0] ead;
  } row_t;

  localparam int NROW = 17;
  // expected occupancy after each edge: tag, 0 = empty
  localparam row_t TBL [NROW] = '{
    '{1'b1,2'd1,4'd1,8'h10,8'h04,1'b1, 4'd1,4'd0,4'd0,4'd0, 1'b0,1'b0,8'h00},
    '{1'b1,2'd1,4'd2,8'h20,8'h08,1'b1, 4'd2,4'd1,4'd0,4'd0, 1'b0,1'b0,8'h00},
    '{1'b1,2'd0,4'd3,8'h00,8'h00,1'b1, 4'd3,4'd2,4'd1,4'd0, 1'b1,1'b0,8'h14}, // R3 overlap
    '{1'b0,2'd0,4'd0,8'h00,8'h00,1'b1, 4'd0,4'd3,4'd2,4'd1, 1'b1,1'b0,8'h28}, // R4 dep ALU
    '{1'b0,2'd0,4'd0,8'h00,8'h00,1'b1, 4'd0,4'd0,4'd3,4'd2, 1'b0,1'b0,8'h00},
    '{1'b0,2'd0,4'd0,8'h00,8'h00,1'b1, 4'd0,4'd0,4'd0,4'd3, 1'b0,1'b0,8'h00},
    '{1'b0,2'd0,4'd0,8'h00,8'h00,1'b1, 4'd0,4'd0,4'd0,4'd0, 1'b0,1'b0,8'h00},
    '{1'b1,2'd1,4'd4,8'h40,8'h10,1'b1, 4'd4,4'd0,4'd0,4'd0, 1'b0,1'b0,8'h00},
    '{1'b1,2'd2,4'd5,8'h50,8'h01,1'b1, 4'd5,4'd4,4'd0,4'd0, 1'b0,1'b0,8'h00},
    '{1'b1,2'd0,4'd6,8'h00,8'h00,1'b1, 4'd6,4'd5,4'd4,4'd0, 1'b1,1'b0,8'h50},
    '{1'b0,2'd0,4'd0,8'h00,8'h00,1'b0, 4'd6,4'd5,4'd4,4'd0, 1'b1,1'b0,8'h50}, // R6 R7 R8 wait
    '{1'b0,2'd0,4'd0,8'h00,8'h00,1'b0, 4'd6,4'd5,4'd4,4'd0, 1'b1,1'b0,8'h50}, // R6 R8 wait
    '{1'b0,2'd0,4'd0,8'h00,8'h00,1'b1, 4'd0,4'd6,4'd5,4'd4, 1'b1,1'b1,8'h51}, // R7 retire
    '{1'b0,2'd0,4'd0,8'h00,8'h00,1'b0, 4'd0,4'd6,4'd5,4'd0, 1'b1,1'b1,8'h51}, // R6 store wait
    '{1'b0,2'd0,4'd0,8'h00,8'h00,1'b1, 4'd0,4'd0,4'd6,4'd5, 1'b0,1'b0,8'h00},
    '{1'b0,2'd0,4'd0,8'h00,8'h00,1'b0, 4'd0,4'd0,4'd0,4'd6, 1'b0,1'b0,8'h00}, // R10 ALU ignores ready
    '{1'b0,2'd0,4'd0,8'h00,8'h00,1'b0, 4'd0,4'd0,4'd0,4'd0, 1'b0,1'b0,8'h00}  // R10 empty
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_stage(input string req, input string nm, input logic v,
                           input logic [3:0] t, input logic [3:0] e);
    chk((v == (e != 0)) && (e == 0 || t == e), req, nm, {27'd0, v, t}, {27'd0, e != 0, e});
  endtask

  task automatic drive(input logic iv, input logic [1:0] kd, input logic [3:0] tg,
                       input logic [31:0] ba, input logic [31:0] of, input logic rd);
    @(negedge clk);
    in_valid = iv; in_kind = kd; in_tag = tg; in_base = ba; in_off = of; bus_ready = rd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    #12;
    chk(!if_v && !de_v && !mem_v && !wb_v, "R1", "valids in reset",
        {28'd0, if_v, de_v, mem_v, wb_v}, 32'd0);
    chk(!bus_req && in_ready, "R1", "req/ready in reset", {30'd0, bus_req, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      row_t r;
      r = TBL[i];
      drive(r.iv, r.kd, r.tg, {24'd0, r.ba}, {24'd0, r.of}, r.rd);
      // R2 stage occupancy
      chk_stage("R2", "if", if_v, if_t, r.eif);
      chk_stage("R2", "de", de_v, de_t, r.ede);
      chk_stage("R2", "mem", mem_v, mem_t, r.emem);
      chk_stage("R2", "wb", wb_v, wb_t, r.ewb);
      // R5 bus request, address, write flag
      chk(bus_req == r.ereq, "R5", "bus_req", {31'd0, bus_req}, {31'd0, r.ereq});
      if (r.ereq) begin
        chk(bus_addr == {24'd0, r.ead}, "R5", "bus_addr", bus_addr, {24'd0, r.ead});
        chk(bus_we == r.ewe, "R5", "bus_we", {31'd0, bus_we}, {31'd0, r.ewe});
      end
    end

    // R9 R6: held decode keeps address while memory waits
    drive(1'b1, 2'd1, 4'd8, 32'h60, 32'h2, 1'b1);
    drive(1'b1, 2'd1, 4'd9, 32'h70, 32'h3, 1'b1);
    drive(1'b1, 2'd0, 4'd10, 32'h0, 32'h0, 1'b1);
    @(negedge clk);
    in_valid = 1'b1; in_kind = 2'd0; in_tag = 4'd11; in_base = '0; in_off = '0; bus_ready = 1'b0;
    #1;
    chk(!in_ready, "R6", "in_ready during wait", {31'd0, in_ready}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #1;
      chk(de_ea == 32'h73, "R9", "de_ea held", de_ea, 32'h73);
      chk_stage("R9", "de held", de_v, de_t, 4'd9);
      chk_stage("R6", "if held", if_v, if_t, 4'd10);
      chk_stage("R7", "wb bubble", wb_v, wb_t, 4'd0);
      chk(bus_addr == 32'h62, "R8", "addr stable", bus_addr, 32'h62);
    end
    @(negedge clk);
    bus_ready = 1'b1;
    @(posedge clk);
    #1;
    chk_stage("R7", "wb after ready", wb_v, wb_t, 4'd8);
    chk_stage("R6", "if takes held input", if_v, if_t, 4'd11);
    chk_stage("R2", "mem after ready", mem_v, mem_t, 4'd9);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    rst_n = 1'b0;
    #1;
    chk(!if_v && !de_v && !mem_v && !wb_v, "R1", "valids after async reset",
        {28'd0, if_v, de_v, mem_v, wb_v}, 32'd0);
    chk(!bus_req && in_ready, "R1", "req/ready after async reset",
        {30'd0, bus_req, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(!if_v && !wb_v, "R1", "idle after release", {30'd0, if_v, wb_v}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule